// File: doc/BRIEF.md
# Range-Routed Address Decoder

This block steers CPU-side addresses to one of four downstream I/O ports. Software programs a bank of 64-bit register triples (window start, size mask, port route) through a simple register bus. Each lookup address is compared at once against four direct windows and two distributed windows. The result is a hit flag, the selected port and the offset of the address inside that port's window. An address that no window claims is flagged as a decode error.

Each direct window sends its whole range to the port chosen by its route word. A distributed window is cut into eight equal slices, one per rope. Only four of the rope positions have a port (ropes 0, 1, 4 and 6). An address in any other slice is not claimed by that window. All outputs are combinational in the lookup address, and register writes take effect on the clock edge that performs them.

Top module: `range_route_dec`

## Requirements
- R1: After reset the register words read as follows (byte offsets relative to the bank; the bank holds word k at 0x300+8k, triple t at words 3t, 3t+1 and 3t+2 as start, mask and route). 0x368 reads 0xFC000000, 0x370 reads 0, 0x398 reads 0xFFFFFF0000, 0x3C0 reads 0xFFFEE00000, 0x3C8 reads 0xFFFFFF0000 and 0x3D0 reads 0. The direct triples (words 0 to 11) read 0, and 0x360 reads the memory distributed start parameter (0xF4000001 by default).
- R2: A 64-bit write (reg_wide_i=1) replaces the whole word, and a 64-bit read returns it.
- R3: A 32-bit write takes its value from reg_wdata_i[31:0]. It replaces the upper half when reg_addr_i[2]=1 and the lower half otherwise, and leaves the other half unchanged. A 32-bit read returns the selected half in reg_rdata_o[31:0], with zeros above.
- R4: A window starts at its start word with bits 11:0 cleared and bits 63:32 forced to ones. Its size is (NOT mask[31:0])+1 with bits 11:0 cleared. An address hits only when its bits 63:32 are all ones and its low 32 bits lie in [start, start+size).
- R5: A window whose start bit 0 is clear, or whose computed size is zero, never hits.
- R6: A direct window hit selects port_o = route word modulo 4.
- R7: offset_o is the address minus the window start for a direct hit. For a distributed hit it is the address minus the start of its slice.
- R8: When several windows hit, the lowest-numbered direct window wins. Any direct window wins over the distributed windows, and the memory distributed window (triple 4) wins over the I/O distributed window (triple 6).
- R9: A distributed window (triples 4 and 6) is split into 8 equal slices numbered from its start. Slices 0, 1, 4 and 6 map to ports 0, 1, 2 and 3. An address in another slice gets no hit from that window.
- R10: With lookup_req_i=1 and no hit, dec_err_o=1. Otherwise dec_err_o=0.
- R11: A write to any word of a triple changes the lookup result in the cycle right after the write's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_wide_i | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| reg_addr_i | input | 12 | Register byte address |
| reg_wdata_i | input | 64 | Write data (32-bit writes use bits 31:0) |
| reg_rdata_o | output | 64 | Combinational read data |
| lookup_req_i | input | 1 | Lookup request qualifier for the error output |
| lookup_addr_i | input | 64 | Address to decode |
| hit_o | output | 1 | A window claims the address |
| port_o | output | 2 | Selected downstream port |
| offset_o | output | 32 | Port-relative offset |
| dec_err_o | output | 1 | Requested lookup matched no window |

## Verification
Lookup and read outputs follow their inputs with zero cycles of latency. The bench drives them on the falling edge and samples 1 ns later, inside the same low phase. Register writes land on the next rising edge and are visible from that edge onward. After each write the bench moves to the following falling edge before it looks up or reads back. This confirms that a triple update affects the very next lookup and no later one.

// File: rtl/rr_pkg.sv
package rr_pkg;
  localparam int PAGE_BITS  = 12;
  localparam int WORD_BYTES = 8;

  typedef struct packed {
    logic        hit;
    logic [1:0]  port;
    logic [31:0] off;
  } rr_result_t;
endpackage

// File: rtl/rr_regfile.sv
module rr_regfile #(
  parameter int          N_WORDS   = 27,
  parameter int          AW        = 12,
  parameter int          REG_BASE  = 'h300,
  parameter int          DM_TRIPLE = 4,
  parameter int          DI_TRIPLE = 6,
  parameter int          ID_TRIPLE = 8,
  parameter logic [63:0] DM_START  = 64'h0000_0000_F400_0001,
  parameter logic [63:0] DI_START  = 64'h0000_0000_FFF8_0001
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic                           wide_i,
  input  logic [AW-1:0]                  addr_i,
  input  logic [63:0]                    wdata_i,
  output logic [63:0]                    rdata_o,
  output logic [N_WORDS-1:0][63:0]       words_o
);
  localparam int IW = AW - 3;

  logic [N_WORDS-1:0][63:0] q;
  logic [AW-1:0]            rel;
  logic [IW-1:0]            idx;
  logic                     in_win;
  logic [63:0]              sel;

  assign rel    = addr_i - AW'(REG_BASE);
  assign idx    = rel[AW-1:3];
  assign in_win = (addr_i >= AW'(REG_BASE)) && (32'(idx) < N_WORDS);
  assign words_o = q;

  function automatic logic [63:0] reset_word(int i);
    if (i == 3*DM_TRIPLE)        return DM_START;
    else if (i == 3*DM_TRIPLE+1) return 64'h0000_0000_FC00_0000;
    else if (i == 3*DI_TRIPLE)   return DI_START;
    else if (i == 3*DI_TRIPLE+1) return 64'h0000_00FF_FFFF_0000;
    else if (i == 3*ID_TRIPLE)   return 64'h0000_00FF_FEE0_0000;
    else if (i == 3*ID_TRIPLE+1) return 64'h0000_00FF_FFFF_0000;
    else                         return 64'h0;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_WORDS; i++) q[i] <= reset_word(i);
    end else if (we_i && in_win) begin
      for (int i = 0; i < N_WORDS; i++) begin
        if (32'(idx) == i) begin
          if (wide_i)          q[i]        <= wdata_i;
          else if (addr_i[2])  q[i][63:32] <= wdata_i[31:0];
          else                 q[i][31:0]  <= wdata_i[31:0];
        end
      end
    end
  end

  always_comb begin
    sel = '0;
    for (int i = 0; i < N_WORDS; i++) if (32'(idx) == i) sel = q[i];
    if (!in_win)        rdata_o = '0;
    else if (wide_i)    rdata_o = sel;
    else if (addr_i[2]) rdata_o = {32'h0, sel[63:32]};
    else                rdata_o = {32'h0, sel[31:0]};
  end

  // R3
  half_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && in_win && !wide_i && !addr_i[2]) |=>
      (q[$past(idx)][63:32] == $past(q[idx][63:32])));
endmodule

// File: rtl/rr_window.sv
module rr_window
  import rr_pkg::*;
(
  input  logic [63:0] start_i,
  input  logic [63:0] mask_i,
  input  logic [63:0] addr_i,
  output logic        hit_o,
  output logic [31:0] off_o,
  output logic [31:0] size_o
);
  logic [31:0] start_al, size_raw;
  logic        unused_bits;

  assign start_al = {start_i[31:PAGE_BITS], {PAGE_BITS{1'b0}}};
  assign size_raw = ~mask_i[31:0] + 32'd1;
  assign size_o   = {size_raw[31:PAGE_BITS], {PAGE_BITS{1'b0}}};
  assign off_o    = addr_i[31:0] - start_al;
  assign hit_o    = start_i[0] && (size_o != '0) && (&addr_i[63:32]) &&
                    (addr_i[31:0] >= start_al) && (off_o < size_o);
  assign unused_bits = ^{start_i[63:32], start_i[PAGE_BITS-1:1], mask_i[63:32]};
endmodule

// File: rtl/rr_slicer.sv
module rr_slicer #(
  parameter int                 ROPES    = 8,
  parameter int                 PORTS    = 4,
  parameter logic [PORTS*3-1:0] ROPE_MAP = {3'd6, 3'd4, 3'd1, 3'd0}
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     win_hit_i,
  input  logic [31:0]              off_i,
  input  logic [31:0]              size_i,
  output logic                     hit_o,
  output logic [$clog2(PORTS)-1:0] port_o,
  output logic [31:0]              off_o
);
  localparam int RB = $clog2(ROPES);
  localparam int PB = $clog2(PORTS);

  logic [31:0]      slice_w;
  logic [RB-1:0]    slice;
  logic [PORTS-1:0] match;

  assign slice_w = size_i >> RB;

  always_comb begin
    slice = '0;
    for (int k = 1; k < ROPES; k++)
      if (off_i >= slice_w * 32'(k)) slice = RB'(k);
  end

  generate
    for (genvar p = 0; p < PORTS; p++) begin : g_map
      assign match[p] = (ROPE_MAP[p*3 +: 3] == 3'(slice));
    end
  endgenerate

  always_comb begin
    port_o = '0;
    for (int p = PORTS-1; p >= 0; p--) if (match[p]) port_o = PB'(p);
  end

  assign hit_o = win_hit_i && (|match);
  assign off_o = off_i - slice_w * 32'(slice);

  // R9
  rope_unique_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match));
  // R7
  slice_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (off_o < slice_w));
endmodule

// File: rtl/range_route_dec.sv
module range_route_dec
  import rr_pkg::*;
#(
  parameter int          N_DIRECT = 4,
  parameter int          N_TRIPLE = 9,
  parameter int          AW       = 12,
  parameter int          REG_BASE = 'h300,
  parameter int          PORTS    = 4,
  parameter int          ROPES    = 8,
  parameter logic [63:0] DM_START = 64'h0000_0000_F400_0001,
  parameter logic [63:0] DI_START = 64'h0000_0000_FFF8_0001
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic        reg_wide_i,
  input  logic [11:0] reg_addr_i,
  input  logic [63:0] reg_wdata_i,
  output logic [63:0] reg_rdata_o,
  input  logic        lookup_req_i,
  input  logic [63:0] lookup_addr_i,
  output logic        hit_o,
  output logic [1:0]  port_o,
  output logic [31:0] offset_o,
  output logic        dec_err_o
);
  localparam int N_WORDS = 3 * N_TRIPLE;
  localparam int N_DIST  = 2;
  localparam int PB      = $clog2(PORTS);
  localparam int DM_T    = 4;
  localparam int DI_T    = 6;
  localparam logic [N_DIST*4-1:0] DIST_T = {4'(DI_T), 4'(DM_T)};

  logic [N_WORDS-1:0][63:0] words;
  rr_result_t dir_res  [N_DIRECT];
  rr_result_t dist_res [N_DIST];
  logic [31:0] dir_size [N_DIRECT];
  logic [N_DIRECT-1:0] dir_hit;
  logic [N_DIST-1:0]   dist_hit;
  logic unused_bits;

  rr_regfile #(
    .N_WORDS(N_WORDS), .AW(AW), .REG_BASE(REG_BASE),
    .DM_TRIPLE(DM_T), .DI_TRIPLE(DI_T), .ID_TRIPLE(8),
    .DM_START(DM_START), .DI_START(DI_START)
  ) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .wide_i(reg_wide_i), .addr_i(reg_addr_i[AW-1:0]),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .words_o(words)
  );

  generate
    for (genvar d = 0; d < N_DIRECT; d++) begin : g_dir
      rr_window u_win (
        .start_i(words[3*d]), .mask_i(words[3*d+1]), .addr_i(lookup_addr_i),
        .hit_o(dir_res[d].hit), .off_o(dir_res[d].off), .size_o(dir_size[d])
      );
      assign dir_res[d].port = words[3*d+2][PB-1:0];
      assign dir_hit[d]      = dir_res[d].hit;

      // R5
      dir_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !words[3*d][0] |-> !dir_hit[d]);
      // R7
      dir_inside_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dir_hit[d] |-> (dir_res[d].off < dir_size[d]));
    end

    for (genvar s = 0; s < N_DIST; s++) begin : g_dist
      localparam int T = int'(DIST_T[s*4 +: 4]);
      logic        w_hit;
      logic [31:0] w_off, w_size;

      rr_window u_win (
        .start_i(words[3*T]), .mask_i(words[3*T+1]), .addr_i(lookup_addr_i),
        .hit_o(w_hit), .off_o(w_off), .size_o(w_size)
      );
      rr_slicer #(.ROPES(ROPES), .PORTS(PORTS)) u_slice (
        .clk_i, .rst_ni,
        .win_hit_i(w_hit), .off_i(w_off), .size_i(w_size),
        .hit_o(dist_res[s].hit), .port_o(dist_res[s].port), .off_o(dist_res[s].off)
      );
      assign dist_hit[s] = dist_res[s].hit;
    end
  endgenerate

  // lowest priority first, later assignments override
  always_comb begin
    hit_o = 1'b0; port_o = '0; offset_o = '0;
    for (int s = N_DIST-1; s >= 0; s--)
      if (dist_res[s].hit) {hit_o, port_o, offset_o} = dist_res[s];
    for (int d = N_DIRECT-1; d >= 0; d--)
      if (dir_res[d].hit) {hit_o, port_o, offset_o} = dir_res[d];
  end

  assign dec_err_o   = lookup_req_i && !hit_o;
  assign unused_bits = ^words;

  // R4
  upper_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (&lookup_addr_i[63:32]));
  // R8
  first_direct_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_hit[0] |-> (hit_o && port_o == words[2][1:0] && offset_o == dir_res[0].off));
  // R10
  miss_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lookup_req_i && dir_hit == '0 && dist_hit == '0) |-> dec_err_o);
endmodule

// File: tb/range_route_dec_test.sv
module range_route_dec_test;
  logic        clk = 0;
  logic        rst_ni = 0;
  logic        reg_we = 0, reg_wide = 1;
  logic [11:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0, reg_rdata;
  logic        req = 0;
  logic [63:0] laddr = '0;
  logic        hit, derr;
  logic [1:0]  port;
  logic [31:0] off;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  range_route_dec uut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we), .reg_wide_i(reg_wide),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .lookup_req_i(req), .lookup_addr_i(laddr), .hit_o(hit), .port_o(port),
    .offset_o(off), .dec_err_o(derr)
  );

  // addr, hit, port, offset
  localparam int NV = 16;
  localparam logic [98:0] VEC [NV] = '{
    {64'hFFFF_FFFF_A000_0000, 1'b1, 2'd2, 32'h0},      // R6 route 6
    {64'hFFFF_FFFF_A00F_9000, 1'b1, 2'd2, 32'hF_9000}, // R8 overlap
    {64'hFFFF_FFFF_A010_0000, 1'b1, 2'd1, 32'h8000},   // R7
    {64'hFFFF_FFFF_A010_7FFF, 1'b1, 2'd1, 32'hFFFF},   // R4 top edge
    {64'hFFFF_FFFF_A010_8000, 1'b0, 2'd0, 32'h0},      // R10
    {64'h0000_0000_A000_0000, 1'b0, 2'd0, 32'h0},      // R4 upper bits
    {64'hFFFF_FFFF_B000_0010, 1'b0, 2'd0, 32'h0},      // R5 disabled
    {64'hFFFF_FFFF_C000_0FFF, 1'b1, 2'd3, 32'hFFF},    // R4 aligned start
    {64'hFFFF_FFFF_C000_1000, 1'b0, 2'd0, 32'h0},      // R4 aligned size
    {64'hFFFF_FFFF_F400_0010, 1'b1, 2'd0, 32'h10},     // R9 rope 0
    {64'hFFFF_FFFF_F480_0004, 1'b1, 2'd1, 32'h4},      // R9 rope 1
    {64'hFFFF_FFFF_F500_0000, 1'b0, 2'd0, 32'h0},      // R9 rope 2
    {64'hFFFF_FFFF_F600_0100, 1'b1, 2'd2, 32'h100},    // R9 rope 4
    {64'hFFFF_FFFF_F701_2345, 1'b1, 2'd3, 32'h1_2345}, // R9 rope 6
    {64'hFFFF_FFFF_FFF8_2004, 1'b1, 2'd1, 32'h4},      // R9 io rope 1
    {64'hFFFF_FFFF_FFF8_6000, 1'b0, 2'd0, 32'h0}       // R9 io rope 3
  };

  task automatic chk(input bit ok, input string req_tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d, input bit wide);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d; reg_wide = wide;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [11:0] a, input bit wide, input logic [63:0] exp, input string req_tag);
    reg_addr = a; reg_wide = wide;
    #1;
    chk(reg_rdata === exp, req_tag, reg_rdata, exp);
  endtask

  task automatic look(input logic [63:0] a, input bit eh, input logic [1:0] ep,
                      input logic [31:0] eo, input string req_tag);
    req = 1; laddr = a;
    #1;
    chk(hit === eh, {req_tag, " hit"}, 64'(hit), 64'(eh));
    chk(derr === !eh, {req_tag, " R10 err"}, 64'(derr), 64'(!eh));
    if (eh) begin
      chk(port === ep, {req_tag, " port"}, 64'(port), 64'(ep));
      chk(off === eo, {req_tag, " offset"}, 64'(off), 64'(eo));
    end
  endtask

  initial begin : watchdog
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    rd(12'h368, 1, 64'hFC00_0000, "R1");
    rd(12'h370, 1, 64'h0, "R1");
    rd(12'h398, 1, 64'hFF_FFFF_0000, "R1");
    rd(12'h3C0, 1, 64'hFF_FEE0_0000, "R1");
    rd(12'h3C8, 1, 64'hFF_FFFF_0000, "R1");
    rd(12'h3D0, 1, 64'h0, "R1");
    rd(12'h300, 1, 64'h0, "R1");
    rd(12'h360, 1, 64'hF400_0001, "R1");
    look(64'hFFFF_FFFF_A000_0000, 0, 0, 0, "R1 no direct");

    // direct triples
    wr(12'h300, 64'hA000_0001, 1); wr(12'h308, 64'hFFF0_0000, 1); wr(12'h310, 64'd6, 1);
    wr(12'h318, 64'hA00F_8001, 1); wr(12'h320, 64'hFFFF_0000, 1); wr(12'h328, 64'd1, 1);
    wr(12'h330, 64'hB000_0000, 1); wr(12'h338, 64'hFFFF_0000, 1); wr(12'h340, 64'd3, 1);
    wr(12'h348, 64'hC000_0FFF, 1); wr(12'h350, 64'hFFFF_E800, 1); wr(12'h358, 64'd7, 1);
    rd(12'h318, 1, 64'hA00F_8001, "R2");

    // R3 half writes on a spare word
    wr(12'h378, 64'h1111_2222_3333_4444, 1);
    wr(12'h37C, 64'hFFFF_FFFF_DEAD_BEEF, 0);
    rd(12'h378, 1, 64'hDEAD_BEEF_3333_4444, "R3");
    rd(12'h37C, 0, 64'hDEAD_BEEF, "R3");
    wr(12'h378, 64'h0000_0000_5555_6666, 0);
    rd(12'h378, 0, 64'h5555_6666, "R3");
    rd(12'h378, 1, 64'hDEAD_BEEF_5555_6666, "R3");

    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      look(VEC[i][98:35], VEC[i][34], VEC[i][33:32], VEC[i][31:0],
           $sformatf("R4/R6/R7/R9 vec%0d", i));
    end

    // R8 direct over distributed, R11 visible right after the write edge
    look(64'hFFFF_FFFF_F400_0010, 1, 2'd0, 32'h10, "R11 before");
    wr(12'h338, 64'hFFFF_F000, 1);
    wr(12'h340, 64'd2, 1);
    wr(12'h330, 64'hF400_0001, 1);
    look(64'hFFFF_FFFF_F400_0010, 1, 2'd2, 32'h10, "R8 R11");

    // R5 zero size via 32-bit mask write
    look(64'hFFFF_FFFF_C000_0000, 1, 2'd3, 32'h0, "R5 before");
    wr(12'h350, 64'hFFFF_FFFF, 0);
    look(64'hFFFF_FFFF_C000_0000, 0, 0, 0, "R5 zero size");

    // R10 no error without request
    req = 0; laddr = 64'h0; #1;
    chk(derr === 1'b0, "R10 idle", 64'(derr), 64'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule